// File: doc/BRIEF.md
# SPI Register-Access Target with Flow-Control Wait Bytes

This block lets an SPI host (mode 0, clock idle low, data sampled on the rising edge) read or write a 24-bit register space behind it. Every transaction opens with a four-byte command header. The first header byte gives the direction and the payload size. The next three bytes give the register address.

After the header, the target answers with wait bytes until a register back end signals that it is ready. It then sends one release byte, and the payload follows with no further pauses. The host recognises wait and release bytes by their least significant bit. The register offset is the header address minus a window base.

SCLK, CS_n and MOSI are oversampled in the system clock domain through two-flop synchronisers. The back end sees a one-cycle request pulse carrying the direction, offset and length. For a read, it answers by raising `be_ready` with the read bytes on `be_rd_data`. For a write, it raises `be_ready` to let the payload proceed. The buffered write data is handed over with a one-cycle pulse only when chip select rises at the end of a complete write. Writing past the end of the write buffer raises an error flag that lasts until chip select rises.

Top module: `spi_regacc_target`

## Requirements
- R1: After the fourth header byte, `req_valid` pulses for exactly one cycle per transaction. The command fields are decoded from the header as follows:
  - header byte 0 bit 7 = 1 means read, so `cmd_write` = 0;
  - `cmd_len` = (header byte 0 bits 5:0) + 1;
  - `cmd_offset` = ({byte 1, byte 2, byte 3} − BASE_ADDR) mod 2^24, where byte 1 is the most significant.
- R2: MISO is 0 while CS_n is high, and the four response bytes sent during the header are all 0x00. The least significant bit of the fourth byte is therefore always 0, which requests a wait.
- R3: Each response byte after the header is 0x00 (wait) until `be_ready` has been sampled high during the wait phase. The first byte loaded at a byte boundary after that sample is 0x01 (release). `be_ready` at any other time has no effect.
- R4: In a read, the N-th byte after the release byte (N from 0) is bits 8N+7:8N of `be_rd_data`, as captured in the cycle `be_ready` was accepted. Later changes on `be_rd_data` do not alter it. Positions at or beyond `cmd_len` or BUF_BYTES return 0x00. No wait byte appears after the release byte.
- R5: In a write, the N-th MOSI byte after the release byte is stored at bits 8N+7:8N of `wr_data`, and MISO bytes during the payload are 0x00. If at least `cmd_len` payload bytes were received when CS_n rises, `wr_valid` pulses for one cycle. Buffer positions not written in that transaction read 0.
- R6: A write whose CS_n rises after fewer than `cmd_len` payload bytes produces no `wr_valid`.
- R7: MOSI bytes sent during wait bytes, during the release byte and during a read payload have no effect on the read data or on `wr_data`.
- R8: A write payload byte arriving when BUF_BYTES bytes are already stored sets `err`. After that, every response byte is 0x01, the transaction does not commit, and `err` clears when CS_n rises.
- R9: A CS_n rise at any point, including mid-wait, returns the target to header reception. The next transaction then behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from the host (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| req_valid | output | 1 | One-cycle pulse when a header has been decoded |
| cmd_write | output | 1 | 1 for a write command, 0 for a read |
| cmd_offset | output | 24 | Register offset (address minus BASE_ADDR) |
| cmd_len | output | 7 | Payload length, 1 to 64 |
| be_ready | input | 1 | Back end ready; releases the wait |
| be_rd_data | input | BUF_BYTES*8 | Read bytes, byte N at bits 8N+7:8N |
| wr_valid | output | 1 | One-cycle pulse handing over a completed write |
| wr_data | output | BUF_BYTES*8 | Buffered write payload |
| err | output | 1 | Write buffer overflow, held until chip select rises |

## Verification
The bench builds the block with BUF_BYTES = 8 and the default base 0xD40000. The small buffer makes an overflow reachable with a 9th payload byte. It also makes a 12-byte read run past the buffer, so the zero fill of both the length limit and the buffer limit is exercised. Back-end latencies range from one cycle to several byte times. This gives both the minimum single wait byte and multi-byte stalls. One address below the base exercises the wrapping subtraction.

// File: rtl/spi_ra_pkg.sv
package spi_ra_pkg;

    typedef enum logic [2:0] {
        PH_HDR,
        PH_WAIT,
        PH_REL,
        PH_DATA,
        PH_ERR
    } phase_t;

    localparam int          HDR_BYTES = 4;
    localparam logic [7:0]  RSP_HOLD  = 8'h00;
    localparam logic [7:0]  RSP_GO    = 8'h01;

    typedef struct packed {
        logic        is_read;
        logic [6:0]  len;
        logic [23:0] addr;
    } hdr_t;

    function automatic hdr_t decode_hdr(input logic [31:0] raw);
        hdr_t d;
        d.is_read = raw[31];
        d.len     = {1'b0, raw[29:24]} + 7'd1;
        d.addr    = raw[23:0];
        return d;
    endfunction

endpackage

// File: rtl/spi_ra_sync.sv
module spi_ra_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/spi_ra_shift.sv
module spi_ra_shift
    import spi_ra_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_s,
    input  logic       cs_n_s,
    input  logic       mosi_s,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    output logic       cs_start,
    output logic       cs_end
);
    logic       sclk_q;
    logic       cs_n_q;
    logic [2:0] bitcnt;
    logic [6:0] rxsr;
    logic [7:0] txsr;
    logic       rise;
    logic       fall;

    assign rise     = sclk_s & ~sclk_q;
    assign fall     = ~sclk_s & sclk_q;
    assign cs_start = cs_n_q & ~cs_n_s;
    assign cs_end   = ~cs_n_q & cs_n_s;
    assign miso     = txsr[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q     <= 1'b0;
            cs_n_q     <= 1'b1;
            bitcnt     <= '0;
            rxsr       <= '0;
            txsr       <= '0;
            byte_valid <= 1'b0;
            rx_byte    <= '0;
        end else begin
            sclk_q     <= sclk_s;
            cs_n_q     <= cs_n_s;
            byte_valid <= 1'b0;
            if (cs_n_s) begin
                bitcnt <= '0;
                txsr   <= '0;
            end else if (cs_start) begin
                bitcnt <= '0;
                txsr   <= RSP_HOLD;
            end else begin
                if (rise) begin
                    rxsr   <= {rxsr[5:0], mosi_s};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        byte_valid <= 1'b1;
                        rx_byte    <= {rxsr, mosi_s};
                    end
                end else if (fall && bitcnt != 3'd0) begin
                    txsr <= {txsr[6:0], 1'b0};
                end
                if (tx_load) begin
                    txsr <= tx_byte;
                end
            end
        end
    end
endmodule

// File: rtl/spi_ra_ctrl.sv
module spi_ra_ctrl
    import spi_ra_pkg::*;
#(
    parameter int          BUF_BYTES = 64,
    parameter logic [23:0] BASE_ADDR = 24'hD40000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   byte_valid,
    input  logic [7:0]             rx_byte,
    input  logic                   cs_start,
    input  logic                   cs_end,
    input  logic                   be_ready,
    input  logic [BUF_BYTES*8-1:0] be_rd_data,
    output logic                   tx_load,
    output logic [7:0]             tx_byte,
    output logic                   req_valid,
    output logic                   cmd_write,
    output logic [23:0]            cmd_offset,
    output logic [6:0]             cmd_len,
    output logic                   wr_valid,
    output logic [BUF_BYTES*8-1:0] wr_data,
    output logic                   err,
    output phase_t                 ph,
    output logic                   ready_seen
);
    localparam int BUF_W = BUF_BYTES * 8;
    localparam int IDX_W = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;
    localparam int CNT_W = 8;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] BUF_LIM = CNT_W'(BUF_BYTES);

    logic [1:0]       hidx;
    logic [23:0]      hdr_sr;
    logic [CNT_W-1:0] cnt;
    logic [BUF_W-1:0] rd_buf;
    logic [BUF_W-1:0] wr_buf;
    logic [7:0]       rd_pick;
    logic             len_met;
    hdr_t             hd;

    assign hd      = decode_hdr({hdr_sr, rx_byte});
    assign wr_data = wr_buf;
    assign err     = (ph == PH_ERR);
    assign len_met = (cnt >= {1'b0, cmd_len});

    always_comb begin
        rd_pick = 8'h00;
        if (cnt < {1'b0, cmd_len} && cnt < BUF_LIM) begin
            rd_pick = rd_buf[{cnt[IDX_W-1:0], 3'b000} +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_HDR;
            hidx       <= '0;
            hdr_sr     <= '0;
            cnt        <= '0;
            ready_seen <= 1'b0;
            rd_buf     <= '0;
            wr_buf     <= '0;
            tx_load    <= 1'b0;
            tx_byte    <= RSP_HOLD;
            req_valid  <= 1'b0;
            wr_valid   <= 1'b0;
            cmd_write  <= 1'b0;
            cmd_offset <= '0;
            cmd_len    <= 7'd1;
        end else begin
            tx_load   <= 1'b0;
            req_valid <= 1'b0;
            wr_valid  <= 1'b0;

            if (ph == PH_WAIT && be_ready && !ready_seen) begin
                ready_seen <= 1'b1;
                if (!cmd_write) begin
                    rd_buf <= be_rd_data;
                end
            end

            if (cs_end) begin
                if (ph == PH_DATA && cmd_write && len_met) begin
                    wr_valid <= 1'b1;
                end
                ph         <= PH_HDR;
                hidx       <= '0;
                ready_seen <= 1'b0;
            end else if (cs_start) begin
                ph         <= PH_HDR;
                hidx       <= '0;
                ready_seen <= 1'b0;
            end else if (byte_valid) begin
                tx_load <= 1'b1;
                unique case (ph)
                    PH_HDR: begin
                        tx_byte <= RSP_HOLD;
                        if (hidx == 2'(HDR_BYTES - 1)) begin
                            cmd_write  <= ~hd.is_read;
                            cmd_len    <= hd.len;
                            cmd_offset <= hd.addr - BASE_ADDR;
                            req_valid  <= 1'b1;
                            ready_seen <= 1'b0;
                            wr_buf     <= '0;
                            ph         <= PH_WAIT;
                        end else begin
                            hdr_sr <= {hdr_sr[15:0], rx_byte};
                            hidx   <= hidx + 2'd1;
                        end
                    end
                    PH_WAIT: begin
                        if (ready_seen) begin
                            tx_byte <= RSP_GO;
                            ph      <= PH_REL;
                        end else begin
                            tx_byte <= RSP_HOLD;
                        end
                    end
                    PH_REL: begin
                        ph <= PH_DATA;
                        if (cmd_write) begin
                            tx_byte <= 8'h00;
                            cnt     <= '0;
                        end else begin
                            tx_byte <= rd_buf[7:0];
                            cnt     <= CNT_W'(1);
                        end
                    end
                    PH_DATA: begin
                        if (cmd_write) begin
                            if (cnt >= BUF_LIM) begin
                                tx_byte <= RSP_GO;
                                ph      <= PH_ERR;
                            end else begin
                                wr_buf[{cnt[IDX_W-1:0], 3'b000} +: 8] <= rx_byte;
                                cnt     <= cnt + CNT_W'(1);
                                tx_byte <= 8'h00;
                            end
                        end else begin
                            tx_byte <= rd_pick;
                            if (cnt != CNT_MAX) begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    default: begin
                        tx_byte <= RSP_GO;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_regacc_target.sv
module spi_regacc_target
    import spi_ra_pkg::*;
#(
    parameter int          BUF_BYTES = 64,
    parameter logic [23:0] BASE_ADDR = 24'hD40000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   spi_sclk,
    input  logic                   spi_cs_n,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic                   req_valid,
    output logic                   cmd_write,
    output logic [23:0]            cmd_offset,
    output logic [6:0]             cmd_len,
    input  logic                   be_ready,
    input  logic [BUF_BYTES*8-1:0] be_rd_data,
    output logic                   wr_valid,
    output logic [BUF_BYTES*8-1:0] wr_data,
    output logic                   err
);
    logic [2:0] pins_s;
    logic       tx_load;
    logic [7:0] tx_byte;
    logic       byte_valid;
    logic [7:0] rx_byte;
    logic       cs_start;
    logic       cs_end;
    phase_t     ph;
    logic       ready_seen;

    // bit 2: SCLK, bit 1: CS_n (idles high), bit 0: MOSI
    spi_ra_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q   (pins_s)
    );

    spi_ra_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (pins_s[2]),
        .cs_n_s     (pins_s[1]),
        .mosi_s     (pins_s[0]),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte),
        .miso       (spi_miso),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .cs_start   (cs_start),
        .cs_end     (cs_end)
    );

    spi_ra_ctrl #(.BUF_BYTES(BUF_BYTES), .BASE_ADDR(BASE_ADDR)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .cs_start   (cs_start),
        .cs_end     (cs_end),
        .be_ready   (be_ready),
        .be_rd_data (be_rd_data),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte),
        .req_valid  (req_valid),
        .cmd_write  (cmd_write),
        .cmd_offset (cmd_offset),
        .cmd_len    (cmd_len),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .err        (err),
        .ph         (ph),
        .ready_seen (ready_seen)
    );
endmodule

// File: rtl/spi_ra_chk.sv
module spi_ra_chk
    import spi_ra_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input phase_t ph,
    input logic   ready_seen,
    input logic   req_valid,
    input logic   wr_valid,
    input logic   cmd_write,
    input logic   err
);
    // R1
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R5
    commit_dir_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> cmd_write);

    // R8
    err_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> !wr_valid);

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ERR) |=> (ph == PH_ERR || ph == PH_HDR));

    // R4
    no_restall_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DATA) |=> (ph inside {PH_DATA, PH_HDR, PH_ERR}));

    // R3
    release_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_REL && $past(ph) == PH_WAIT) |-> $past(ready_seen));
endmodule

bind spi_regacc_target spi_ra_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ph         (ph),
    .ready_seen (ready_seen),
    .req_valid  (req_valid),
    .wr_valid   (wr_valid),
    .cmd_write  (cmd_write),
    .err        (err)
);

// File: tb/tb_spi_regacc_target.sv
module tb_spi_regacc_target;
    localparam int          BUF  = 8;
    localparam logic [23:0] BASE = 24'hD40000;
    localparam int          HALF = 8;

    typedef struct packed {
        logic        rd;
        logic [6:0]  len;
        logic [23:0] addr;
        logic [15:0] delay;
        logic [7:0]  seed;
        logic [7:0]  extra;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'd4,  24'hD40010, 16'd2,   8'h11, 8'd0},
        '{1'b1, 7'd4,  24'hD40024, 16'd2,   8'h5A, 8'd2},
        '{1'b1, 7'd1,  24'hD40000, 16'd400, 8'h33, 8'd0},
        '{1'b0, 7'd8,  24'hD400FF, 16'd250, 8'hC0, 8'd0},
        '{1'b1, 7'd12, 24'hD40100, 16'd0,   8'h07, 8'd0},
        '{1'b0, 7'd1,  24'h000005, 16'd1,   8'h99, 8'd0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             spi_sclk = 1'b0;
    logic             spi_cs_n = 1'b1;
    logic             spi_mosi = 1'b0;
    logic             spi_miso;
    logic             req_valid;
    logic             cmd_write;
    logic [23:0]      cmd_offset;
    logic [6:0]       cmd_len;
    logic             be_ready = 1'b0;
    logic [BUF*8-1:0] be_rd_data = '0;
    logic             wr_valid;
    logic [BUF*8-1:0] wr_data;
    logic             err;

    always #2 clk = ~clk;

    spi_regacc_target #(.BUF_BYTES(BUF), .BASE_ADDR(BASE)) dut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .req_valid(req_valid),
        .cmd_write(cmd_write), .cmd_offset(cmd_offset), .cmd_len(cmd_len),
        .be_ready(be_ready), .be_rd_data(be_rd_data), .wr_valid(wr_valid),
        .wr_data(wr_data), .err(err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    function automatic logic [7:0] pat(input logic [7:0] s, input int k);
        return s + 8'(k * 29);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // back-end model, driven on the falling clock edge
    int          req_cnt = 0;
    int          wr_cnt = 0;
    logic [23:0] cap_off;
    logic [6:0]  cap_len;
    logic        cap_wr;
    logic [BUF*8-1:0] wr_cap;
    int          be_delay = 0;
    int          dcnt = 0;
    bit          pend = 0;
    logic [7:0]  cur_seed = 0;

    always @(negedge clk) begin
        if (wr_valid) begin
            wr_cnt++;
            wr_cap = wr_data;
        end
        if (req_valid) begin
            req_cnt++;
            cap_off  = cmd_offset;
            cap_len  = cmd_len;
            cap_wr   = cmd_write;
            pend     = 1;
            dcnt     = be_delay;
            be_ready = 1'b0;
        end else if (be_ready) begin
            be_ready   = 1'b0;
            be_rd_data = '1;
        end else if (pend) begin
            if (dcnt == 0) begin
                be_ready = 1'b1;
                pend     = 0;
                for (int k = 0; k < BUF; k++) be_rd_data[k*8 +: 8] = pat(cur_seed, k);
            end else begin
                dcnt--;
            end
        end
    end

    task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = mo[b];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            mi[b] = spi_miso;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    logic [7:0] hdr_mi [4];
    logic [7:0] pay_mi [80];
    logic [7:0] rel_b;
    int         nstall;
    int         stall_bad;

    task automatic run_xfer(input logic rd, input logic [6:0] len, input logic [23:0] addr,
                            input int npay, input int abort_at, input bit close);
        logic [7:0] hb [4];
        logic [7:0] b;
        hb[0] = {rd, 1'b0, 6'(len - 7'd1)};
        hb[1] = addr[23:16];
        hb[2] = addr[15:8];
        hb[3] = addr[7:0];
        nstall = 0;
        stall_bad = 0;
        rel_b = 8'h00;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 4; i++) spi_byte(hb[i], hdr_mi[i]);
        b = 8'h00;
        while (!b[0] && nstall < 60 && !(abort_at >= 0 && nstall >= abort_at)) begin
            spi_byte(8'hA5, b);
            if (b[0]) rel_b = b;
            else begin
                nstall++;
                if (b != 8'h00) stall_bad++;
            end
        end
        if (b[0]) begin
            for (int k = 0; k < npay; k++) begin
                if (rd) spi_byte(8'h5A ^ 8'(k), pay_mi[k]);
                else    spi_byte(pat(cur_seed, k), pay_mi[k]);
            end
        end
        if (close) begin
            repeat (HALF) @(negedge clk);
            spi_cs_n = 1'b1;
            repeat (20) @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int rq0, wr0, first_bad, nexp;
        logic [BUF*8-1:0] wexp;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R2: reset state
        chk(spi_miso == 1'b0, "R2 miso idle after reset", 64'(spi_miso), 0);
        chk(err == 1'b0 && req_valid == 1'b0 && wr_valid == 1'b0,
            "R8 outputs idle after reset", {err, req_valid, wr_valid}, 0);

        for (int v = 0; v < NV; v++) begin
            cur_seed = VECS[v].seed;
            be_delay = int'(VECS[v].delay);
            rq0 = req_cnt;
            wr0 = wr_cnt;
            run_xfer(VECS[v].rd, VECS[v].len, VECS[v].addr,
                     int'(VECS[v].len) + int'(VECS[v].extra), -1, 1'b1);
            chk({hdr_mi[0], hdr_mi[1], hdr_mi[2], hdr_mi[3]} == 32'h0,
                "R2 header response bytes", {hdr_mi[0], hdr_mi[1], hdr_mi[2], hdr_mi[3]}, 0);
            chk(req_cnt == rq0 + 1, "R1 one request per transaction", req_cnt - rq0, 1);
            chk(cap_off == VECS[v].addr - BASE, "R1 offset", cap_off, VECS[v].addr - BASE);
            chk(cap_len == VECS[v].len && cap_wr == !VECS[v].rd, "R1 length/direction",
                {cap_wr, cap_len}, {!VECS[v].rd, VECS[v].len});
            chk(rel_b == 8'h01 && stall_bad == 0, "R3 release byte and wait bytes",
                {rel_b, 8'(stall_bad)}, 16'h0100);
            if (VECS[v].delay < 16'd40)
                chk(nstall == 1, "R3 minimum stall", nstall, 1);
            else
                chk(nstall >= 2 && nstall <= int'(VECS[v].delay) / 128 + 3,
                    "R3 stall bounded by latency", nstall, int'(VECS[v].delay) / 128 + 1);
            if (VECS[v].rd) begin
                first_bad = -1;
                nexp = int'(VECS[v].len) + int'(VECS[v].extra);
                for (int k = 0; k < nexp; k++) begin
                    logic [7:0] e;
                    e = (k < int'(VECS[v].len) && k < BUF) ? pat(cur_seed, k) : 8'h00;
                    if (pay_mi[k] != e && first_bad < 0) first_bad = k;
                end
                chk(first_bad < 0, "R4 R7 read payload", first_bad, -1);
                chk(wr_cnt == wr0, "R5 no commit on read", wr_cnt - wr0, 0);
            end else begin
                first_bad = -1;
                for (int k = 0; k < int'(VECS[v].len); k++)
                    if (pay_mi[k] != 8'h00 && first_bad < 0) first_bad = k;
                chk(first_bad < 0, "R5 miso zero in write payload", first_bad, -1);
                wexp = '0;
                for (int k = 0; k < int'(VECS[v].len); k++) wexp[k*8 +: 8] = pat(cur_seed, k);
                chk(wr_cnt == wr0 + 1, "R5 one commit", wr_cnt - wr0, 1);
                chk(wr_cap == wexp, "R5 R7 write data", wr_cap, wexp);
            end
        end

        // R6: short write is aborted
        cur_seed = 8'h42;
        be_delay = 2;
        wr0 = wr_cnt;
        run_xfer(1'b0, 7'd4, 24'hD40008, 2, -1, 1'b1);
        chk(wr_cnt == wr0, "R6 short write not committed", wr_cnt - wr0, 0);

        // R8: overflow with a 9th payload byte
        cur_seed = 8'h21;
        be_delay = 2;
        wr0 = wr_cnt;
        run_xfer(1'b0, 7'd8, 24'hD40040, 10, -1, 1'b0);
        repeat (HALF) @(negedge clk);
        chk(err == 1'b1, "R8 err raised on overflow", 64'(err), 1);
        chk(pay_mi[9] == 8'h01 && pay_mi[8] == 8'h00, "R8 response after overflow",
            {pay_mi[8], pay_mi[9]}, 16'h0001);
        spi_cs_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(err == 1'b0, "R8 err cleared by chip select", 64'(err), 0);
        chk(wr_cnt == wr0, "R8 no commit after overflow", wr_cnt - wr0, 0);

        // R9: abort during the wait phase, then a normal read
        be_delay = 3000;
        rq0 = req_cnt;
        run_xfer(1'b1, 7'd2, 24'hD40200, 0, 1, 1'b1);
        chk(req_cnt == rq0 + 1 && err == 1'b0, "R9 aborted read", req_cnt - rq0, 1);
        repeat (3200) @(negedge clk);
        chk(spi_miso == 1'b0, "R2 miso low between transactions", 64'(spi_miso), 0);
        cur_seed = 8'h6E;
        be_delay = 2;
        run_xfer(1'b1, 7'd2, 24'hD40200, 2, -1, 1'b1);
        chk(nstall == 1 && rel_b == 8'h01, "R9 R3 recovery after abort", nstall, 1);
        chk(pay_mi[0] == pat(8'h6E, 0) && pay_mi[1] == pat(8'h6E, 1),
            "R9 R4 read after abort", {pay_mi[0], pay_mi[1]}, {pat(8'h6E, 0), pat(8'h6E, 1)});

        done = 1;
        finish_run();
    end
endmodule